// File: doc/BRIEF.md
# Linked-Word Dual Serial Output Formatter

The block turns up to seven 16-bit parallel data words, plus a built-in all-zeros word, into two serial bit streams, A and B. The words and their order come from a link table. Each stream has a field that names its starting source. Each source has a field that names the source sent after it. Together these fields form one or two chains through the captured words. Both streams carry the same number of words. A source other than the zeros word can be used only once across the two streams.

A load strobe captures all source words at once, with their tag bits already applied, into two chained shift registers, and starts a frame. Each word takes 17 bit slots: 16 data bits, sent MSB first, and one sync slot. The sync slot comes either just before the MSB or just after the LSB. The bit slot rate is the system clock divided by 1, 2, 4, 8 or 16. The block drives a serial clock, with selectable polarity, that rises where each new bit begins. The sync output has selectable polarity. Between frames the data pins are low and the sync output is inactive.

Top module: `dual_serial_formatter`

## Requirements
- R1: A `load` high at a rising clock edge while `busy` is low captures the source words and the configuration, and the frame begins at that edge. A `load` while `busy` is high has no effect, and changes to `src_bus` after the capture do not alter the frame.
- R2: Source identifiers are 0 I, 1 Q, 2 magnitude, 3 phase, 4 frequency, 5 timing error, 6 AGC gain and 7 all-zeros. Source k (k = 0..6) is `src_bus[16k+15:16k]`. Stream A starts with `cfg_first_a` and stream B with `cfg_first_b`. The source that follows source x is `cfg_link[3x+2:3x]`. Each stream carries `cfg_count` words, and a count of 0 is treated as 1.
- R3: Each word is sent MSB first. The tag field of source x is `cfg_tag[2x+1:2x]`. Values 0 and 1 send the true LSB, 2 forces the LSB to 0 and 3 forces it to 1.
- R4: A word takes 17 slots. With `cfg_sync_after`=0, slot 0 is the sync slot and slots 1..16 carry bits 15..0. With `cfg_sync_after`=1, slots 0..15 carry bits 15..0 and slot 16 is the sync slot. Both data outputs are low during a sync slot.
- R5: `ser_sync` is high during sync slots and low elsewhere when `cfg_sync_low`=0. When `cfg_sync_low`=1, both levels are inverted.
- R6: A slot lasts P clock cycles, where P = 1, 2, 4, 8, 16 for `cfg_div` = 0..4 and P = 16 for any larger value. Slot s of a frame begins at the (s·P)-th edge after the accepting edge. For P ≥ 2 the internal serial clock is high for the first P/2 cycles of each slot and low for the rest. For P = 1 it follows `clk`. `ser_clk` is the internal serial clock XOR `cfg_clk_inv`.
- R7: Stream A's chain is resolved before stream B's. If a chain reaches a source other than 7 that either stream has already used, that word and all later words of the same stream become zeros. `link_err` is then set, and it stays set until reset. Source 7 may repeat without error.
- R8: While idle and after reset, `ser_a` and `ser_b` are 0, `ser_sync` is at its inactive level, `ser_clk` equals `cfg_clk_inv`, and `busy` and `link_err` are 0.
- R9: `busy` is high from the accepting edge until the edge that ends the last slot, which comes 17·count·P cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_bus | input | 112 | Seven 16-bit source words, source k at bits 16k+15:16k |
| load | input | 1 | Capture strobe that starts a frame |
| cfg_div | input | 3 | Slot period selector |
| cfg_clk_inv | input | 1 | Inverts the serial clock output |
| cfg_sync_after | input | 1 | 0: sync slot before the MSB, 1: sync slot after the LSB |
| cfg_sync_low | input | 1 | Makes the sync output active low |
| cfg_tag | input | 16 | Two-bit LSB tag control per source |
| cfg_first_a | input | 3 | First source of stream A |
| cfg_first_b | input | 3 | First source of stream B |
| cfg_link | input | 24 | Three-bit successor field per source |
| cfg_count | input | 3 | Words per stream (0 treated as 1) |
| ser_a | output | 1 | Serial data of stream A |
| ser_b | output | 1 | Serial data of stream B |
| ser_clk | output | 1 | Serial shift clock |
| ser_sync | output | 1 | Per-word sync |
| busy | output | 1 | Frame in progress |
| link_err | output | 1 | Sticky flag for a repeated source |

## Verification
The bench runs a sweep of frames. Each frame uses its own mix of slot period, sync position, both polarities, word count (0 included), tag fields, starting sources and link tables. The link tables are built as affine permutations, so some chains close into loops and others cross into the other stream. This separates a correct successor lookup and repeat detection from a design that just walks the sources in order. Every slot of every frame is compared with a bench-side model. The serial clock is also sampled in both halves of each slot, which would catch a wrong divide ratio or a clock that rises away from the data change. Odd frames add a load pulse mid-frame and new source values after capture, to show that the captured frame is left intact. A reset partway through the sweep shows that the sticky error flag clears.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int WORD_W    = 16;
  localparam int NSRC      = 8;
  localparam int ID_W      = $clog2(NSRC);
  localparam int MAX_WORDS = NSRC - 1;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int TAG_W     = 2;

  // slot length in system clock cycles for a divide code
  function automatic logic [4:0] period_of(input logic [2:0] div);
    case (div)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // replace the LSB when the tag field asks for it
  function automatic logic [WORD_W-1:0] tag_lsb(input logic [WORD_W-1:0] w,
                                                input logic [TAG_W-1:0] tag);
    logic [WORD_W-1:0] r;
    r = w;
    if (tag[1]) r[0] = tag[0];
    return r;
  endfunction
endpackage

// File: rtl/sfmt_clkdiv.sv
module sfmt_clkdiv #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [2:0] div,
  output logic       tick,
  output logic       sclk
);
  import sfmt_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [4:0]       per;

  assign per     = period_of(div);
  assign tick    = run && ({{(5-CNT_W){1'b0}}, cnt} == per - 5'd1);
  assign cnt_nxt = tick ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      sclk <= (per > 5'd1);
    end else if (run) begin
      cnt  <= cnt_nxt;
      sclk <= ({{(5-CNT_W){1'b0}}, cnt_nxt} < (per >> 1));
    end else begin
      sclk <= 1'b0;
    end
  end

  assert_div_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !start) |=> (cnt == $past(cnt) + 1'b1));
  assert_div_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start) |=> (cnt == '0));
endmodule

// File: rtl/sfmt_linker.sv
module sfmt_linker #(
  parameter int ID_W      = 3,
  parameter int MAX_WORDS = 7,
  parameter int CNT_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ID_W-1:0]               first_a,
  input  logic [ID_W-1:0]               first_b,
  input  logic [(2**ID_W)*ID_W-1:0]     link,
  input  logic [CNT_W-1:0]              count,
  output logic [MAX_WORDS*ID_W-1:0]     seq_a,
  output logic [MAX_WORDS*ID_W-1:0]     seq_b,
  output logic                          hit
);
  localparam int NID = 2**ID_W;
  localparam logic [ID_W-1:0] ZID = '1;

  logic [MAX_WORDS*ID_W-1:0] seq_v [2];
  logic [NID-1:0]            used;
  logic [ID_W-1:0]           cur;
  logic [ID_W-1:0]           pick;
  logic                      dead;
  int unsigned               lim;

  always_comb begin
    used     = '0;
    hit      = 1'b0;
    cur      = '0;
    pick     = '0;
    dead     = 1'b0;
    lim      = (count == '0) ? 32'd1 : 32'(count);
    seq_v[0] = '1;
    seq_v[1] = '1;
    for (int s = 0; s < 2; s++) begin
      cur  = (s == 0) ? first_a : first_b;
      dead = 1'b0;
      for (int k = 0; k < MAX_WORDS; k++) begin
        if (k < lim) begin
          if (cur != ZID && used[cur]) begin
            dead = 1'b1;
            hit  = 1'b1;
          end
          pick = dead ? ZID : cur;
          seq_v[s][k*ID_W +: ID_W] = pick;
          if (pick != ZID) used[pick] = 1'b1;
          cur = link[pick*ID_W +: ID_W];
        end
      end
    end
  end

  assign seq_a = seq_v[0];
  assign seq_b = seq_v[1];

  // occurrence count of each real source across both chains, done separately
  logic dup_seen;
  always_comb begin
    dup_seen = 1'b0;
    for (int id = 0; id < NID - 1; id++) begin
      int n;
      n = 0;
      for (int k = 0; k < MAX_WORDS; k++) begin
        if (seq_a[k*ID_W +: ID_W] == ID_W'(id)) n++;
        if (seq_b[k*ID_W +: ID_W] == ID_W'(id)) n++;
      end
      if (n > 1) dup_seen = 1'b1;
    end
  end

  assert_single_use_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_seen);
endmodule

// File: rtl/sfmt_shifter.sv
module sfmt_shifter #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_en,
  input  logic [WORD_W*MAX_WORDS-1:0] load_val,
  input  logic                        shift_en,
  output logic                        bit_out
);
  localparam int LEN = WORD_W * MAX_WORDS;

  logic [LEN-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)        sr <= '0;
    else if (load_en)  sr <= load_val;
    else if (shift_en) sr <= {sr[LEN-2:0], 1'b0};
  end

  assign bit_out = sr[LEN-1];

  assert_shift_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (bit_out == $past(sr[LEN-2])));
endmodule

// File: rtl/dual_serial_formatter.sv
module dual_serial_formatter
  import sfmt_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NS = NSRC,
  parameter int IW = ID_W,
  parameter int MW = MAX_WORDS,
  parameter int CW = CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [(NS-1)*W-1:0] src_bus,
  input  logic                load,
  input  logic [2:0]          cfg_div,
  input  logic                cfg_clk_inv,
  input  logic                cfg_sync_after,
  input  logic                cfg_sync_low,
  input  logic [NS*TAG_W-1:0] cfg_tag,
  input  logic [IW-1:0]       cfg_first_a,
  input  logic [IW-1:0]       cfg_first_b,
  input  logic [NS*IW-1:0]    cfg_link,
  input  logic [CW-1:0]       cfg_count,
  output logic                ser_a,
  output logic                ser_b,
  output logic                ser_clk,
  output logic                ser_sync,
  output logic                busy,
  output logic                link_err
);
  localparam int LEN      = W * MW;
  localparam int BIT_W    = $clog2(W + 1);
  localparam logic [BIT_W-1:0] LAST_SLOT = BIT_W'(W);

  // named events
  logic          accept;
  logic          tick;
  logic          sclk_q;
  logic          data_slot;
  logic          last_bit;
  logic          frame_end;
  logic          shift_en;
  logic          link_hit;

  logic [2:0]       f_div;
  logic             f_after;
  logic [CW-1:0]    f_count;
  logic [BIT_W-1:0] bit_i;
  logic [CW-1:0]    word_i;
  logic [CW-1:0]    cnt_eff;

  logic [MW*IW-1:0] seq [2];
  logic [LEN-1:0]   load_val [2];
  logic [1:0]       bit_out;

  function automatic logic [W-1:0] src_of(input logic [IW-1:0] id,
                                          input logic [(NS-1)*W-1:0] bus);
    logic [W-1:0] r;
    r = '0;
    for (int k = 0; k < NS - 1; k++)
      if (id == IW'(k)) r = bus[k*W +: W];
    return r;
  endfunction

  assign accept    = load && !busy;
  assign cnt_eff   = (cfg_count == '0) ? CW'(1) : cfg_count;
  assign data_slot = f_after ? (bit_i < LAST_SLOT) : (bit_i != '0);
  assign last_bit  = (bit_i == LAST_SLOT);
  assign shift_en  = busy && tick && data_slot;
  assign frame_end = busy && tick && last_bit && (word_i == f_count - 1'b1);

  sfmt_linker #(.ID_W(IW), .MAX_WORDS(MW), .CNT_W(CW)) u_linker (
    .clk(clk), .rst_n(rst_n),
    .first_a(cfg_first_a), .first_b(cfg_first_b),
    .link(cfg_link), .count(cfg_count),
    .seq_a(seq[0]), .seq_b(seq[1]), .hit(link_hit)
  );

  sfmt_clkdiv #(.CNT_W(4)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy),
    .div(accept ? cfg_div : f_div), .tick(tick), .sclk(sclk_q)
  );

  for (genvar s = 0; s < 2; s++) begin : g_stream
    always_comb begin
      load_val[s] = '0;
      for (int k = 0; k < MW; k++) begin
        logic [IW-1:0] id;
        id = seq[s][k*IW +: IW];
        load_val[s][LEN-1-k*W -: W] =
          tag_lsb(src_of(id, src_bus), cfg_tag[id*TAG_W +: TAG_W]);
      end
    end

    sfmt_shifter #(.WORD_W(W), .MAX_WORDS(MW)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_en(accept), .load_val(load_val[s]),
      .shift_en(shift_en), .bit_out(bit_out[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      link_err <= 1'b0;
      f_div    <= '0;
      f_after  <= 1'b0;
      f_count  <= CW'(1);
      bit_i    <= '0;
      word_i   <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      link_err <= link_err | link_hit;
      f_div    <= cfg_div;
      f_after  <= cfg_sync_after;
      f_count  <= cnt_eff;
      bit_i    <= '0;
      word_i   <= '0;
    end else if (busy && tick) begin
      if (frame_end) busy <= 1'b0;
      if (last_bit) begin
        bit_i  <= '0;
        word_i <= word_i + 1'b1;
      end else begin
        bit_i  <= bit_i + 1'b1;
      end
    end
  end

  assign ser_a    = busy && data_slot && bit_out[0];
  assign ser_b    = busy && data_slot && bit_out[1];
  assign ser_sync = (busy && !data_slot) ^ cfg_sync_low;
  assign ser_clk  = busy ? (((f_div == 3'd0) ? clk : sclk_q) ^ cfg_clk_inv)
                         : cfg_clk_inv;

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |=> link_err);
  assert_load_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> (busy && $stable(f_count) && $stable(f_div)));
  assert_frame_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy);
  assert_word_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (word_i < f_count));
endmodule

// File: tb/test_dual_serial_formatter.sv
`timescale 1ns/1ps
module test_dual_serial_formatter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [111:0] src_bus = '0;
  logic         load = 1'b0;
  logic [2:0]   cfg_div = '0;
  logic         cfg_clk_inv = 1'b0, cfg_sync_after = 1'b0, cfg_sync_low = 1'b0;
  logic [15:0]  cfg_tag = '0;
  logic [2:0]   cfg_first_a = '0, cfg_first_b = '0, cfg_count = '0;
  logic [23:0]  cfg_link = '0;
  logic         ser_a, ser_b, ser_clk, ser_sync, busy, link_err;

  int checks = 0;
  int failures = 0;
  logic exp_err = 1'b0;

  always #4 clk = ~clk;

  dual_serial_formatter i_dual_serial_formatter (
    .clk(clk), .rst_n(rst_n), .src_bus(src_bus), .load(load),
    .cfg_div(cfg_div), .cfg_clk_inv(cfg_clk_inv),
    .cfg_sync_after(cfg_sync_after), .cfg_sync_low(cfg_sync_low),
    .cfg_tag(cfg_tag), .cfg_first_a(cfg_first_a), .cfg_first_b(cfg_first_b),
    .cfg_link(cfg_link), .cfg_count(cfg_count),
    .ser_a(ser_a), .ser_b(ser_b), .ser_clk(ser_clk), .ser_sync(ser_sync),
    .busy(busy), .link_err(link_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 actual=running expected=done");
    summary();
  end

  function automatic logic [15:0] src_word(input int t, input int id);
    return 16'((id * 16'h1357) ^ (t * 16'h00F1) ^ 16'h8421);
  endfunction

  task automatic check_idle(input string tag);
    chk(tag, {3'b0, ser_a, ser_b, ser_sync, ser_clk, busy},
        {3'b0, 1'b0, 1'b0, cfg_sync_low, cfg_clk_inv, 1'b0});
    chk({tag, " R7 flag"}, {7'b0, link_err}, {7'b0, exp_err});
  endtask

  task automatic run_frame(input int t);
    int per, lim, total, mulv, addv, x, id;
    int ord [2][7];
    bit taken [8];
    bit blocked;
    logic [15:0] words [2][7];
    logic [15:0] w;
    logic [2:0] fa, fb, d3;
    logic eb0, eb1, es;

    d3  = (t % 11 == 10) ? 3'd6 : 3'(t % 5);
    per = (d3 >= 3'd4) ? 16 : (1 << d3);
    cfg_div        = d3;
    cfg_sync_after = 1'((t / 5) % 2);
    cfg_sync_low   = 1'((t / 2) % 2);
    cfg_clk_inv    = 1'((t / 3) % 2);
    cfg_count      = 3'(t % 8);
    cfg_tag        = 16'(t * 40503 + 12345);
    mulv = 2 * (t % 4) + 1;
    addv = t % 8;
    for (int i = 0; i < 8; i++) cfg_link[i*3 +: 3] = 3'((i * mulv + addv) % 8);
    fa = 3'(t % 8);
    fb = 3'((t * 5 + 3) % 8);
    cfg_first_a = fa;
    cfg_first_b = fb;
    for (int i = 0; i < 7; i++) src_bus[i*16 +: 16] = src_word(t, i);

    // bench model of the chains (R2, R7)
    lim = (t % 8 == 0) ? 1 : t % 8;
    for (int i = 0; i < 8; i++) taken[i] = 0;
    for (int s = 0; s < 2; s++) begin
      blocked = 0;
      x = (s == 0) ? int'(fa) : int'(fb);
      for (int k = 0; k < lim; k++) begin
        if (!blocked && x != 7 && taken[x]) begin
          blocked = 1;
          exp_err = 1'b1;
        end
        id = blocked ? 7 : x;
        ord[s][k] = id;
        if (id != 7) taken[id] = 1;
        w = (id == 7) ? 16'h0 : src_word(t, id);
        if (cfg_tag[id*2 + 1]) w[0] = cfg_tag[id*2];
        words[s][k] = w;
        x = int'(cfg_link[id*3 +: 3]);
      end
    end
    total = lim * 17;

    load = 1'b1;
    @(posedge clk);
    for (int s = 0; s < total; s++) begin
      int wi, b, dix;
      @(negedge clk);
      load = 1'b0;
      if (s == 0) begin
        chk("R9 busy at frame start", {7'b0, busy}, 8'h01);
        // new source values after capture must not show (R1)
        for (int i = 0; i < 7; i++) src_bus[i*16 +: 16] = ~src_word(t, i);
      end
      wi = s / 17;
      b  = s % 17;
      es = cfg_sync_after ? (b == 16) : (b == 0);
      dix = cfg_sync_after ? b : b - 1;
      eb0 = es ? 1'b0 : words[0][wi][15 - dix];
      eb1 = es ? 1'b0 : words[1][wi][15 - dix];
      chk("R1 R2 R3 R4 R5 R6 slot", {4'b0, ser_a, ser_b, ser_sync, ser_clk},
          {4'b0, eb0, eb1, es ^ cfg_sync_low,
           ((per > 1) ? 1'b1 : 1'b0) ^ cfg_clk_inv});
      if ((t % 2 == 1) && s == total / 2) load = 1'b1;
      for (int j = 1; j < per; j++) begin
        @(negedge clk);
        load = 1'b0;
        if (j == per / 2)
          chk("R6 clock low half", {7'b0, ser_clk}, {7'b0, cfg_clk_inv});
      end
    end
    @(negedge clk);
    check_idle("R8 R9 idle after frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R8 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R8 idle before load");
    for (int t = 0; t < 48; t++) begin
      if (t == 30) begin
        rst_n = 1'b0;
        exp_err = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle("R7 R8 flag cleared by reset");
        rst_n = 1'b1;
        @(negedge clk);
      end
      run_frame(t);
      repeat (2) @(negedge clk);
    end
    summary();
  end
endmodule